// File: doc/BRIEF.md
# Multi-Source Interrupt Level Controller

This block gathers up to thirty-two level-sensitive interrupt lines and turns them into a 4-bit priority level for each of several processors. The lines come from onboard devices, seven expansion-bus levels, seven backplane-bus levels and four asynchronous error sources. Several sources share each priority level. The level seen by a processor is therefore formed by OR-ing fixed groups of unmasked source bits and then picking the highest group that is active.

Software controls the block through a small word-addressed register port. A global mask can only be changed through two atomic ports: one sets mask bits and the other clears them. A target register chooses which processor receives the shared device interrupts. Error interrupts go to every processor. Each processor also has its own pending word, with set and clear ports, so that any processor can post a software interrupt at any level to any processor. Each processor also has a local timer request line.

Address map (word addresses, default four processors). Global words: 0 is the raw source lines (read only), 1 is the mask (read only), 2 is the mask-set port, 3 is the mask-clear port, and 4 is the target. Processor c uses address 16+4c for its pending word, 17+4c for its set port and 18+4c for its clear port. The set and clear ports also read back the value they change.

Top module: `ilc_top`

## Requirements
- R1: At reset the mask reads 0xFFFFFFFF, the target reads 0, every pending word reads 0 apart from bit 7, and every processor level is 0.
- R2: A write to the mask-set port (address 2) sets each mask bit whose data bit is 1 and leaves the others alone. Addresses 1, 2 and 3 all read back the current mask.
- R3: A write to the mask-clear port (address 3) clears each mask bit whose data bit is 1 and leaves the others alone.
- R4: While mask bit 31 is 1, no global source reaches any processor, whatever the other mask bits hold. A source counts as active when its line is 1 and its mask bit is 0.
- R5: The source bits are: 30 module error, 29 write-buffer error, 28 ECC error, 27 backplane error, 22 floppy, 21 module interrupt, 20 video, 19 system timer, 18 SCSI, 17 audio, 16 Ethernet, 15 serial, 14 keyboard/mouse. Expansion level x (1..7) is bit x+6 and backplane level x is bit x-1.
- R6: Level groups: 2 = both bus level 1; 3 = both bus level 2; 4 = SCSI; 5 = both bus level 3; 6 = Ethernet; 7 = both bus level 4; 8 = video; 9 = both bus level 5 plus module error; 10 = system timer; 11 = both bus level 6 plus floppy; 12 = serial plus keyboard/mouse; 13 = both bus level 7 plus audio; 15 = any of bits 27..30.
- R7: The device groups at levels 2 to 13 reach only the processor named by the target register (address 4).
- R8: The error group at level 15 reaches every processor.
- R9: Each processor's output is the highest level among its active requests, or 0 when it has none. It is registered, so it changes one clock after the inputs or state that cause it.
- R10: Writing ones to a processor's set port sets pending bits 17..31, and writing ones to its clear port clears them. Bit 16+x requests level x on that processor only. Bits 0..16 of these writes are ignored.
- R11: The processor's timer line reads back as bit 7 of its pending word and requests level 14 on that processor, whatever the mask holds.
- R12: Module interrupt (bit 21) and bits 23..26 and 31 of the source lines request no level. Address 0 reads the raw source lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_irq | input | 32 | Global source lines, level sensitive |
| cpu_timer_irq | input | NCPU (4) | Per-processor timer requests |
| cpu_pil | output | 4*NCPU (16) | Level for processor c in bits 4c+3..4c |

## Verification
The assertions assume that the register port issues at most one write per clock, so a set and a clear never reach the same register in the same cycle. They also assume that the source and timer lines are synchronous to the clock and hold each value for at least a full cycle. The bench keeps to these rules: it drives every input on the falling edge through single-write tasks, and it changes the lines only between writes. Its sweeps cover every source bit under every target, every software level on every processor, and random mixes of masks, lines and pending bits.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

    localparam int WORD_W  = 32;
    localparam int PIL_W   = 4;
    localparam int NUM_PIL = 1 << PIL_W;

    localparam int BIT_ALL_OFF   = 31;
    localparam int BIT_MOD_ERR   = 30;
    localparam int BIT_FLOPPY    = 22;
    localparam int BIT_VIDEO     = 20;
    localparam int BIT_SYSTIMER  = 19;
    localparam int BIT_SCSI      = 18;
    localparam int BIT_AUDIO     = 17;
    localparam int BIT_ENET      = 16;
    localparam int BIT_SERIAL    = 15;
    localparam int BIT_KBDMS     = 14;
    localparam int BIT_TIMER_LOC = 7;
    localparam int SW_BASE       = 16;

    localparam logic [WORD_W-1:0] ERR_BITS = 32'h7800_0000;
    localparam logic [WORD_W-1:0] SW_BITS  = 32'hFFFE_0000;

    typedef enum logic [2:0] {
        G_LINES = 3'd0,
        G_MASK  = 3'd1,
        G_MSET  = 3'd2,
        G_MCLR  = 3'd3,
        G_TGT   = 3'd4
    } glob_off_e;

    typedef enum logic [1:0] {
        C_PEND = 2'd0,
        C_SET  = 2'd1,
        C_CLR  = 2'd2
    } cpu_off_e;

    typedef struct packed {
        logic              set;
        logic              clr;
        logic [WORD_W-1:0] data;
    } sc_cmd_t;

    function automatic logic [WORD_W-1:0] bit_of(input int n);
        return WORD_W'(1) << n;
    endfunction

    // Both buses at the same bus level: expansion bit lvl+6, backplane bit lvl-1
    function automatic logic [WORD_W-1:0] bus_pair(input int lvl);
        return bit_of(lvl + 6) | bit_of(lvl - 1);
    endfunction

    // Source bits shared by one device level (2..13); error level handled apart
    function automatic logic [WORD_W-1:0] group_bits(input int pil);
        case (pil)
            2:       return bus_pair(1);
            3:       return bus_pair(2);
            4:       return bit_of(BIT_SCSI);
            5:       return bus_pair(3);
            6:       return bit_of(BIT_ENET);
            7:       return bus_pair(4);
            8:       return bit_of(BIT_VIDEO);
            9:       return bus_pair(5) | bit_of(BIT_MOD_ERR);
            10:      return bit_of(BIT_SYSTIMER);
            11:      return bus_pair(6) | bit_of(BIT_FLOPPY);
            12:      return bit_of(BIT_SERIAL) | bit_of(BIT_KBDMS);
            13:      return bus_pair(7) | bit_of(BIT_AUDIO);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/ilc_sc_reg.sv
module ilc_sc_reg
    import ilc_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VAL = '1,
    parameter logic [WORD_W-1:0] LIVE    = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  sc_cmd_t           cmd,
    output logic [WORD_W-1:0] q
);

    logic [WORD_W-1:0] hit;
    assign hit = cmd.data & LIVE;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL & LIVE;
        end else if (cmd.set) begin
            q <= q | hit;
        end else if (cmd.clr) begin
            q <= q & ~hit;
        end
    end

    // R2 (and R10 for pending words): set port raises every selected bit
    assert_set_port_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd.set && !cmd.clr) |=> ((q & $past(hit)) == $past(hit)));

    // R3 (and R10): clear port drops every selected bit
    assert_clr_port_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr && !cmd.set) |=> ((q & $past(hit)) == '0));

    // R2/R3: zero bits are untouched by either port
    assert_other_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd.set || cmd.clr) |=> ((q & ~$past(hit)) == ($past(q) & ~$past(hit))));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!cmd.set && !cmd.clr) |=> $stable(q));

endmodule

// File: rtl/ilc_level_enc.sv
module ilc_level_enc
    import ilc_pkg::*;
(
    input  logic [NUM_PIL-1:0] req,
    output logic [PIL_W-1:0]   lvl
);

    always_comb begin
        lvl = '0;
        for (int p = 1; p < NUM_PIL; p++) begin
            if (req[p]) lvl = PIL_W'(p);
        end
    end

endmodule

// File: rtl/ilc_cpu_level.sv
module ilc_cpu_level
    import ilc_pkg::*;
(
    input  logic [WORD_W-1:0] dev_act,
    input  logic              is_target,
    input  logic [WORD_W-1:0] sw_pend,
    input  logic              timer_req,
    output logic [PIL_W-1:0]  lvl
);

    logic [NUM_PIL-1:0] req;
    logic               err_any;

    assign err_any = |(dev_act & ERR_BITS);
    assign req[0]  = 1'b0;

    for (genvar p = 1; p < NUM_PIL; p++) begin : g_pil
        if (p == NUM_PIL - 1) begin : g_err
            assign req[p] = err_any | sw_pend[SW_BASE + p];
        end else if (p == NUM_PIL - 2) begin : g_tmr
            assign req[p] = timer_req | sw_pend[SW_BASE + p];
        end else begin : g_dev
            localparam logic [WORD_W-1:0] GRP = group_bits(p);
            assign req[p] = (is_target && |(dev_act & GRP)) | sw_pend[SW_BASE + p];
        end
    end

    ilc_level_enc u_enc (
        .req (req),
        .lvl (lvl)
    );

endmodule

// File: rtl/ilc_top.sv
module ilc_top
    import ilc_pkg::*;
#(
    parameter  int NCPU   = 4,
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int ADDR_W = ((CPU_W + 2 > 3) ? CPU_W + 2 : 3) + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    input  logic [WORD_W-1:0]     src_irq,
    input  logic [NCPU-1:0]       cpu_timer_irq,
    output logic [NCPU*PIL_W-1:0] cpu_pil
);

    localparam int NSLOT = 1 << CPU_W;

    logic                  in_cpu;
    glob_off_e             g_off;
    cpu_off_e              c_off;
    logic [CPU_W-1:0]      c_idx;

    assign in_cpu = reg_addr[ADDR_W-1];
    assign g_off  = glob_off_e'(reg_addr[2:0]);
    assign c_off  = cpu_off_e'(reg_addr[1:0]);
    assign c_idx  = reg_addr[CPU_W+1:2];

    // Global mask
    sc_cmd_t           mask_cmd;
    logic [WORD_W-1:0] mask_q;
    logic [WORD_W-1:0] dev_act;

    assign mask_cmd.set  = reg_we && !in_cpu && (g_off == G_MSET);
    assign mask_cmd.clr  = reg_we && !in_cpu && (g_off == G_MCLR);
    assign mask_cmd.data = reg_wdata;

    ilc_sc_reg #(.RST_VAL('1), .LIVE('1)) u_mask (
        .clk (clk),
        .rst (rst),
        .cmd (mask_cmd),
        .q   (mask_q)
    );

    assign dev_act = mask_q[BIT_ALL_OFF] ? '0 : (src_irq & ~mask_q);

    // Undirected-interrupt target
    logic [CPU_W-1:0] tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= '0;
        end else if (reg_we && !in_cpu && (g_off == G_TGT)) begin
            tgt_q <= reg_wdata[CPU_W-1:0];
        end
    end

    // Per-processor state and level
    logic [WORD_W-1:0] pend_word [NSLOT];

    for (genvar c = 0; c < NSLOT; c++) begin : g_cpu
        if (c < NCPU) begin : g_live
            sc_cmd_t           sw_cmd;
            logic [WORD_W-1:0] pend_q;
            logic [PIL_W-1:0]  lvl_d;
            logic [PIL_W-1:0]  pil_q;
            logic              sel;

            assign sel         = reg_we && in_cpu && (c_idx == CPU_W'(c));
            assign sw_cmd.set  = sel && (c_off == C_SET);
            assign sw_cmd.clr  = sel && (c_off == C_CLR);
            assign sw_cmd.data = reg_wdata;

            ilc_sc_reg #(.RST_VAL('0), .LIVE(SW_BITS)) u_pend (
                .clk (clk),
                .rst (rst),
                .cmd (sw_cmd),
                .q   (pend_q)
            );

            ilc_cpu_level u_lvl (
                .dev_act   (dev_act),
                .is_target (tgt_q == CPU_W'(c)),
                .sw_pend   (pend_q),
                .timer_req (cpu_timer_irq[c]),
                .lvl       (lvl_d)
            );

            always_ff @(posedge clk) begin
                if (rst) pil_q <= '0;
                else     pil_q <= lvl_d;
            end

            assign cpu_pil[c*PIL_W +: PIL_W] = pil_q;
            assign pend_word[c] = pend_q | (WORD_W'(cpu_timer_irq[c]) << BIT_TIMER_LOC);

            // R8: any active error source drives every processor to level 15
            assert_err_broadcast_R8: assert property (@(posedge clk) disable iff (rst)
                (|(src_irq & ~mask_q & ERR_BITS) && !mask_q[BIT_ALL_OFF])
                |=> (pil_q == PIL_W'(NUM_PIL - 1)));

            // R4: global mask-all leaves only local requests
            assert_mask_all_R4: assert property (@(posedge clk) disable iff (rst)
                (mask_q[BIT_ALL_OFF] && (pend_q == '0) && !cpu_timer_irq[c])
                |=> (pil_q == '0));

            // R7: a non-target processor sees no device level
            assert_non_target_R7: assert property (@(posedge clk) disable iff (rst)
                ((tgt_q != CPU_W'(c)) && (pend_q == '0) && !cpu_timer_irq[c]
                 && ((dev_act & ERR_BITS) == '0))
                |=> (pil_q == '0));

            // R11: timer line alone yields at least level 14
            assert_timer_R11: assert property (@(posedge clk) disable iff (rst)
                cpu_timer_irq[c] |=> (pil_q >= PIL_W'(NUM_PIL - 2)));
        end else begin : g_none
            assign pend_word[c] = '0;
        end
    end

    // Read path
    always_comb begin
        reg_rdata = '0;
        if (in_cpu) begin
            if (c_off != cpu_off_e'(2'd3)) reg_rdata = pend_word[c_idx];
        end else begin
            case (g_off)
                G_LINES: reg_rdata = src_irq;
                G_MASK,
                G_MSET,
                G_MCLR:  reg_rdata = mask_q;
                G_TGT:   reg_rdata = WORD_W'(tgt_q);
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: tb/tb_ilc_top.sv
module tb_ilc_top;

    localparam int NCPU = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                reg_we = 1'b0;
    logic [4:0]          reg_addr = '0;
    logic [31:0]         reg_wdata = '0;
    logic [31:0]         reg_rdata;
    logic [31:0]         src_irq = '0;
    logic [NCPU-1:0]     cpu_timer_irq = '0;
    logic [NCPU*4-1:0]   cpu_pil;

    always #2 clk = ~clk;

    ilc_top #(.NCPU(NCPU)) dut (
        .clk           (clk),
        .rst           (rst),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .src_irq       (src_irq),
        .cpu_timer_irq (cpu_timer_irq),
        .cpu_pil       (cpu_pil)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_mask;
    int          m_tgt;
    logic [31:0] m_sw [NCPU];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_pil(input int c);
        logic [31:0] eff;
        logic [3:0]  lv;
        logic        r;
        int          l;
        eff = m_mask[31] ? 32'h0 : (src_irq & ~m_mask);
        lv = 0;
        for (int p = 1; p < 16; p++) begin
            r = m_sw[c][16 + p];
            if (p == 14) r |= cpu_timer_irq[c];
            if (p == 15) r |= |eff[30:27];
            if (c == m_tgt && p >= 2 && p <= 13) begin
                if (p == 2 || (p % 2) == 1) begin
                    l = (p == 2) ? 1 : (p + 1) / 2;
                    r |= eff[l + 6] | eff[l - 1];
                end
                case (p)
                    4:  r |= eff[18];
                    6:  r |= eff[16];
                    8:  r |= eff[20];
                    9:  r |= eff[30];
                    10: r |= eff[19];
                    11: r |= eff[22];
                    12: r |= eff[15] | eff[14];
                    13: r |= eff[17];
                    default: ;
                endcase
            end
            if (r) lv = 4'(p);
        end
        return lv;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic mask_set(input logic [31:0] d);
        wr(5'd2, d); m_mask |= d;
    endtask
    task automatic mask_clr(input logic [31:0] d);
        wr(5'd3, d); m_mask &= ~d;
    endtask
    task automatic set_tgt(input int t);
        wr(5'd4, 32'(t)); m_tgt = t;
    endtask
    task automatic sw_set(input int c, input logic [31:0] d);
        wr(5'(16 + 4*c + 1), d); m_sw[c] |= d & 32'hFFFE_0000;
    endtask
    task automatic sw_clr(input int c, input logic [31:0] d);
        wr(5'(16 + 4*c + 2), d); m_sw[c] &= ~(d & 32'hFFFE_0000);
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NCPU; c++)
            check(tag, 32'(cpu_pil[c*4 +: 4]), 32'(exp_pil(c)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        m_mask = 32'hFFFF_FFFF;
        m_tgt  = 0;
        for (int c = 0; c < NCPU; c++) m_sw[c] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(5'd1, d); check("R1 mask", d, 32'hFFFF_FFFF);
        rd(5'd4, d); check("R1 target", d, 32'h0);
        for (int c = 0; c < NCPU; c++) begin
            rd(5'(16 + 4*c), d); check("R1 pending", d, 32'h0);
        end
        check("R1 levels", 32'(cpu_pil), 32'h0);
        src_irq = 32'hFFFF_FFFF; settle(); settle();
        check("R1 masked lines", 32'(cpu_pil), 32'h0);
        rd(5'd0, d); check("R12 raw lines", d, 32'hFFFF_FFFF);
        src_irq = '0;

        // R2/R3: set and clear ports
        mask_clr(32'h0000_FFFF);
        rd(5'd1, d); check("R3 clear port", d, 32'hFFFF_0000);
        mask_set(32'h0000_0F00);
        rd(5'd2, d); check("R2 set port", d, 32'hFFFF_0F00);
        mask_clr(32'h0000_0000);
        rd(5'd3, d); check("R3 zero write", d, 32'hFFFF_0F00);
        mask_set(32'h0000_0000);
        rd(5'd1, d); check("R2 zero write", d, 32'hFFFF_0F00);

        // R5/R6/R7/R8/R12: every source bit under every target
        mask_clr(32'hFFFF_FFFF);
        rd(5'd1, d); check("R3 clear all", d, 32'h0);
        for (int t = 0; t < NCPU; t++) begin
            set_tgt(t);
            rd(5'd4, d); check("R7 target readback", d, 32'(t));
            for (int b = 0; b < 32; b++) begin
                src_irq = 32'h1 << b;
                settle();
                check_all($sformatf("R6 bit %0d tgt %0d", b, t));
            end
            src_irq = '0;
        end
        src_irq = 32'h0020_0000; settle();
        check("R12 module int", 32'(cpu_pil), 32'h0);
        src_irq = 32'h1000_0000; settle();
        check("R8 broadcast", 32'(cpu_pil), 32'hFFFF);

        // R4: mask-all bit
        src_irq = 32'h7FFF_FFFF;
        mask_set(32'h8000_0000); settle();
        check("R4 mask all", 32'(cpu_pil), 32'h0);
        check_all("R4 mask all model");
        mask_clr(32'h8000_0000); settle();
        check_all("R4 unmask");
        src_irq = '0;

        // R9: highest wins among device groups
        set_tgt(2);
        src_irq = (32'h1 << 18) | (32'h1 << 1) | (32'h1 << 14); settle();
        check("R9 highest", 32'(cpu_pil[8 +: 4]), 32'd12);
        src_irq = '0; settle();
        check("R9 none", 32'(cpu_pil), 32'h0);

        // R10: software levels per processor
        for (int c = 0; c < NCPU; c++) begin
            for (int x = 1; x < 16; x++) begin
                sw_set(c, 32'h1 << (16 + x)); settle();
                rd(5'(16 + 4*c), d);
                check($sformatf("R10 pend c%0d x%0d", c, x), d, m_sw[c]);
                check_all($sformatf("R10 level c%0d x%0d", c, x));
                sw_clr(c, 32'hFFFF_FFFF); settle();
            end
        end
        sw_set(1, 32'h0001_FFFF); settle();
        rd(5'd21, d); check("R10 low bits ignored", d, 32'h0);
        check("R10 no level", 32'(cpu_pil), 32'h0);

        // R11: local timer
        for (int c = 0; c < NCPU; c++) begin
            cpu_timer_irq = 4'(1 << c); settle();
            rd(5'(16 + 4*c), d); check("R11 timer bit", d, 32'h80);
            check_all("R11 timer level");
        end
        mask_set(32'hFFFF_FFFF); settle();
        check("R11 under mask", 32'(cpu_pil[12 +: 4]), 32'd14);
        cpu_timer_irq = '0;

        // R6/R9: random mixes
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 6)
                0: mask_set($urandom & $urandom);
                1: mask_clr($urandom);
                2: set_tgt(int'($urandom % NCPU));
                3: sw_set(int'($urandom % NCPU), $urandom & $urandom & $urandom);
                4: sw_clr(int'($urandom % NCPU), $urandom);
                default: ;
            endcase
            @(negedge clk);
            src_irq = $urandom & $urandom;
            cpu_timer_irq = 4'($urandom & $urandom);
            settle();
            check_all("R9 random mix");
            rd(5'd1, d); check("R2 random mask", d, m_mask);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule